// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block turns a 32-bit IEEE-754 single-precision word into a 16-bit half-precision word. Finite values are rounded to the nearest representable half, and an exact halfway case goes to the result with an even mantissa. The datapath is combinational and ends in one output register, so each result appears one clock after its input.

A producer presents a word together with a valid strobe, and the consumer takes the result when the matching output strobe is high. No flow control is involved. Single-precision subnormals flush to a zero that keeps its sign. All NaNs collapse to a single quiet half NaN pattern. Magnitudes too large for half become infinity. Normal inputs that are too small for a half normal are rounded into the half subnormal range instead of being flushed.

Top module: `f2h_conv`

## Requirements
- R1: Bit 15 of the result always equals bit 31 of the input word. This holds for zeros, infinities, NaNs and finite values.
- R2: An input whose exponent field (bits 30:23) is 0 gives a result with bits 14:0 equal to 0, whatever the mantissa is.
- R3: An input whose exponent field is 0xFF and whose mantissa (bits 22:0) is 0 gives bits 14:0 = 0x7C00, which is infinity.
- R4: An input whose exponent field is 0xFF and whose mantissa is nonzero gives bits 14:0 = 0x7C01, which is exponent 31 with mantissa 1.
- R5: A normal input whose exponent field lies between 143 and 254 gives bits 14:0 = 0x7C00.
- R6: A normal input whose exponent field E lies between 113 and 142 gives a half exponent of E-112. Its half mantissa is the 23-bit mantissa divided by 2^13 and rounded to nearest, with ties going to even.
- R7: A normal input whose exponent field lies between 1 and 112 gives a half exponent of 0. Its half mantissa is the magnitude times 2^24, rounded to nearest with ties to even. Very small magnitudes therefore give 0.
- R8: A rounded mantissa of 1024 clears the mantissa and adds one to the exponent. This produces the smallest half normal (0x0400) from the subnormal path, and infinity (0x7C00) from exponent 30.
- R9: The result is packed with the sign in bit 15, the exponent in bits 14:10 and the mantissa in bits 9:0. For example, 1.0 converts to 0x3C00 and -2.0 converts to 0xC000.
- R10: out_valid equals in_valid delayed by one clock. While rst_n is low, out_valid and out_half are 0.
- R11: In a cycle where in_valid is low, out_half keeps its previous value on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input word valid |
| in_word | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_half | output | 16 | Half-precision result |

## Verification
The assertions check every cycle for the one-cycle valid latency, the held output when no input is valid, the sign pass-through, and the fixed results for zero or subnormal inputs, infinities, NaNs and overflowing exponents. Whether a finite value is rounded correctly, including ties, the carry into the next exponent and the gradual underflow into half subnormals, is shown only by the bench. The bench sweeps every exponent and both signs against chosen rounding-critical mantissas and random words. It compares each result with a value it computes in real arithmetic.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
  localparam int SGL_EXP_W = 8;
  localparam int SGL_MAN_W = 23;
  localparam int HLF_EXP_W = 5;
  localparam int HLF_MAN_W = 10;
  localparam int SGL_W     = 1 + SGL_EXP_W + SGL_MAN_W;
  localparam int HLF_W     = 1 + HLF_EXP_W + HLF_MAN_W;
  localparam int SGL_BIAS  = (1 << (SGL_EXP_W - 1)) - 1;
  localparam int HLF_BIAS  = (1 << (HLF_EXP_W - 1)) - 1;
  localparam int SIG_W     = SGL_MAN_W + 1;
  localparam int MAN_DROP  = SGL_MAN_W - HLF_MAN_W;
  // lowest single exponent field that still maps to a half normal
  localparam int MIN_NORM_E = SGL_BIAS - HLF_BIAS + 1;
  // highest single exponent field that can map to a finite half
  localparam int MAX_FIN_E  = SGL_BIAS + HLF_BIAS;
  // any right shift beyond this leaves only sticky information
  localparam int DROP_CAP   = SIG_W + 1;
  localparam int DROP_W     = $clog2(DROP_CAP + 1);
  localparam int MAG_W      = HLF_W - 1;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_INF,
    CLS_NAN,
    CLS_OVF,
    CLS_FIN
  } cls_e;
endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
  import f2h_pkg::*;
(
  input  logic [SGL_EXP_W-1:0] exp_fld,
  input  logic [SGL_MAN_W-1:0] man_fld,
  output cls_e                 cls,
  output logic [HLF_EXP_W-1:0] base_exp,
  output logic [DROP_W-1:0]    drop
);
  localparam logic [SGL_EXP_W-1:0] EXP_ONES = '1;
  localparam logic [SGL_EXP_W:0]   GAP_REF  = (SGL_EXP_W+1)'(MIN_NORM_E + MAN_DROP);

  logic [SGL_EXP_W:0] gap;

  always_comb begin
    cls      = CLS_FIN;
    base_exp = '0;
    drop     = DROP_W'(DROP_CAP);
    gap      = GAP_REF - {1'b0, exp_fld};
    if (exp_fld == '0) begin
      cls = CLS_ZERO;
    end else if (exp_fld == EXP_ONES) begin
      cls = (man_fld == '0) ? CLS_INF : CLS_NAN;
    end else if (exp_fld > SGL_EXP_W'(MAX_FIN_E)) begin
      cls = CLS_OVF;
    end else if (exp_fld >= SGL_EXP_W'(MIN_NORM_E)) begin
      // normal half: hidden bit of the kept significand adds the final +1
      base_exp = HLF_EXP_W'(exp_fld - SGL_EXP_W'(MIN_NORM_E));
      drop     = DROP_W'(MAN_DROP);
    end else begin
      drop = (gap > (SGL_EXP_W+1)'(DROP_CAP)) ? DROP_W'(DROP_CAP) : gap[DROP_W-1:0];
    end
  end
endmodule

// File: rtl/f2h_align.sv
module f2h_align
  import f2h_pkg::*;
(
  input  logic [SIG_W-1:0]     sig,
  input  logic [DROP_W-1:0]    drop,
  output logic [HLF_MAN_W:0]   kept,
  output logic                 guard,
  output logic                 sticky
);
  logic [SIG_W-1:0]  shifted;
  logic [SIG_W-1:0]  at_guard;
  logic [SIG_W-1:0]  low_mask;
  logic [DROP_W-1:0] gpos;

  always_comb begin
    gpos     = drop - 1'b1;
    shifted  = sig >> drop;
    at_guard = sig >> gpos;
    low_mask = ~({SIG_W{1'b1}} << gpos);
    kept     = shifted[HLF_MAN_W:0];
    guard    = at_guard[0];
    sticky   = |(sig & low_mask);
  end
endmodule

// File: rtl/f2h_round.sv
module f2h_round
  import f2h_pkg::*;
(
  input  logic [HLF_EXP_W-1:0] base_exp,
  input  logic [HLF_MAN_W:0]   kept,
  input  logic                 guard,
  input  logic                 sticky,
  output logic [MAG_W-1:0]     mag
);
  logic bump;

  always_comb begin
    bump = guard & (sticky | kept[0]);
    // a mantissa carry ripples straight into the exponent field
    mag  = {base_exp, {HLF_MAN_W{1'b0}}} + MAG_W'(kept) + MAG_W'(bump);
  end
endmodule

// File: rtl/f2h_conv.sv
module f2h_conv
  import f2h_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        out_valid,
  output logic [15:0] out_half
);
  localparam logic [HLF_EXP_W-1:0] HEXP_ONES = '1;
  localparam logic [HLF_MAN_W-1:0] NAN_MAN   = HLF_MAN_W'(1);

  logic                 sgn;
  logic [SGL_EXP_W-1:0] exp_fld;
  logic [SGL_MAN_W-1:0] man_fld;
  cls_e                 cls;
  logic [HLF_EXP_W-1:0] base_exp;
  logic [DROP_W-1:0]    drop;
  logic [HLF_MAN_W:0]   kept;
  logic                 guard;
  logic                 sticky;
  logic [MAG_W-1:0]     mag;
  logic [HLF_W-1:0]     half_nxt;
  logic                 valid_nxt;
  logic                 half_en;

  assign sgn     = in_word[SGL_W-1];
  assign exp_fld = in_word[SGL_W-2 -: SGL_EXP_W];
  assign man_fld = in_word[SGL_MAN_W-1:0];

  f2h_classify u_cls (
    .exp_fld  (exp_fld),
    .man_fld  (man_fld),
    .cls      (cls),
    .base_exp (base_exp),
    .drop     (drop)
  );

  f2h_align u_aln (
    .sig    ({1'b1, man_fld}),
    .drop   (drop),
    .kept   (kept),
    .guard  (guard),
    .sticky (sticky)
  );

  f2h_round u_rnd (
    .base_exp (base_exp),
    .kept     (kept),
    .guard    (guard),
    .sticky   (sticky),
    .mag      (mag)
  );

  always_comb begin
    unique case (cls)
      CLS_ZERO: half_nxt = {sgn, {MAG_W{1'b0}}};
      CLS_INF,
      CLS_OVF:  half_nxt = {sgn, HEXP_ONES, {HLF_MAN_W{1'b0}}};
      CLS_NAN:  half_nxt = {sgn, HEXP_ONES, NAN_MAN};
      default:  half_nxt = {sgn, mag};
    endcase
    valid_nxt = in_valid;
    half_en   = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_half  <= '0;
    end else begin
      out_valid <= valid_nxt;
      if (half_en) begin
        out_half <= half_nxt;
      end
    end
  end
endmodule

// File: rtl/f2h_conv_chk.sv
module f2h_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic        out_valid,
  input logic [15:0] out_half
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R10
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_half)); // R11
  AST_SIGN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_half[15] == $past(in_word[31])); // R1
  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[30:23] == 8'h00) |=> out_half[14:0] == 15'h0000); // R2
  AST_INF_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[30:23] == 8'hFF && in_word[22:0] == 23'h0) |=> out_half[14:0] == 15'h7C00); // R3
  AST_NAN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[30:23] == 8'hFF && in_word[22:0] != 23'h0) |=> out_half[14:0] == 15'h7C01); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[30:23] > 8'd142 && in_word[30:23] < 8'hFF) |=> out_half[14:0] == 15'h7C00); // R5
endmodule

bind f2h_conv f2h_conv_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_word   (in_word),
  .out_valid (out_valid),
  .out_half  (out_half)
);

// File: tb/f2h_conv_bench.sv
`timescale 1ns/1ps
module f2h_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        out_valid;
  logic [15:0] out_half;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #4 clk = ~clk;

  f2h_conv u_f2h_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_half  (out_half)
  );

  function automatic real pow2(input int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else        for (int i = 0; i < -k; i++) r = r * 0.5;
    return r;
  endfunction

  function automatic longint rne(input real q);
    real    fl = $floor(q);
    real    d  = q - fl;
    longint n  = longint'(fl);
    if (d > 0.5) n = n + 1;
    else if (d == 0.5 && n[0]) n = n + 1;
    return n;
  endfunction

  function automatic logic [15:0] model(input logic [31:0] w);
    logic   s = w[31];
    int     e = int'(w[30:23]);
    logic [22:0] m = w[22:0];
    int     ue;
    real    x;
    longint r;
    if (e == 0)   return {s, 15'h0000};
    if (e == 255) return (m == 0) ? {s, 15'h7C00} : {s, 15'h7C01};
    ue = e - 127;
    if (ue > 15) return {s, 15'h7C00};
    x = real'({1'b1, m}) * pow2(ue - 23);
    if (ue < -14) begin
      r = rne(x * pow2(24));
      return {s, 15'(r)};
    end
    r = rne(x * pow2(10 - ue));
    return {s, 15'((ue + 14) * 1024 + r)};
  endfunction

  function automatic string tag_of(input logic [31:0] w, input logic [15:0] exp_h);
    int e = int'(w[30:23]);
    if (e == 0)   return "R2";
    if (e == 255) return (w[22:0] == 0) ? "R3" : "R4";
    if (e > 142)  return "R5";
    if (e < 113)  return (exp_h[14:10] != 0) ? "R8" : "R7";
    if (int'(exp_h[14:10]) != e - 112) return "R8";
    return "R6";
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp_v,
                       input logic [31:0] w);
    n_chk++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s in=%h actual=%h expected=%h", req, w, got, exp_v);
    end
  endtask

  task automatic send(input logic [31:0] w);
    logic [15:0] ev;
    in_valid = 1'b1;
    in_word  = w;
    ev = model(w);
    @(negedge clk);
    check(tag_of(w, ev), out_half, ev, w);
    check("R1", {15'h0, out_half[15]}, {15'h0, w[31]}, w);
    check("R10", {15'h0, out_valid}, 16'h0001, w);
  endtask

  function automatic logic [22:0] pat(input int k);
    case (k)
      0: return 23'h000000;  1: return 23'h000001;
      2: return 23'h7FFFFF;  3: return 23'h001000;
      4: return 23'h001001;  5: return 23'h003000;
      6: return 23'h002000;  7: return 23'h000FFF;
      8: return 23'h7FF000;  9: return 23'h7FE000;
      10: return 23'h400000; 11: return 23'h3FF000;
      12: return 23'h200001; 13: return 23'h555555;
      default: return 23'($urandom);
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_word  = 32'h3F80_0000;
    repeat (3) @(negedge clk);
    check("R10", {15'h0, out_valid}, 16'h0000, in_word);
    check("R10", out_half, 16'h0000, in_word);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {15'h0, out_valid}, 16'h0000, in_word);

    // R9 packing examples
    send(32'h3F80_0000);
    check("R9", out_half, 16'h3C00, 32'h3F80_0000);
    send(32'hC000_0000);
    check("R9", out_half, 16'hC000, 32'hC000_0000);
    // R8 carry into the smallest normal and into infinity
    send(32'h387F_F000);
    check("R8", out_half, 16'h0400, 32'h387F_F000);
    send(32'h477F_F000);
    check("R8", out_half, 16'h7C00, 32'h477F_F000);
    // R7 exact half of the smallest subnormal ties to zero; just above rounds up
    send(32'h3300_0000);
    check("R7", out_half, 16'h0000, 32'h3300_0000);
    send(32'h3300_0001);
    check("R7", out_half, 16'h0001, 32'h3300_0001);

    // sweep every exponent, both signs, rounding-critical mantissas
    for (int sg = 0; sg < 2; sg++)
      for (int e = 0; e < 256; e++)
        for (int k = 0; k < 16; k++)
          send({sg[0], e[7:0], pat(k)});
    for (int i = 0; i < 3000; i++) send($urandom);

    // R11 hold while idle, R10 valid drops
    send(32'h4049_0FDB);
    held     = out_half;
    in_valid = 1'b0;
    in_word  = 32'hBF80_0000;
    @(negedge clk);
    check("R10", {15'h0, out_valid}, 16'h0000, in_word);
    check("R11", out_half, held, in_word);
    in_word = 32'h7F80_0000;
    @(negedge clk);
    check("R11", out_half, held, in_word);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule